// File: doc/BRIEF.md
# Parallel-Port Target Interface Decoder

This block sits on the target side of a synchronous parallel port that a USB bridge controller drives. The bus can be 8 or 16 bits wide. One data bus carries both commands and buffer data, and a separate select line decides which one a transfer is. Reads and writes each arrive as a pair of strobes, one active-high and one active-low, and the two copies must agree. The block samples all of these on every rising edge of the interface clock, which the bridge supplies (48 MHz in the intended system). It then decodes one operation per cycle.

A command-phase write loads a command register and gives a one-cycle notification pulse. A data-phase write stores a word into a 512-entry buffer. A data-phase read returns a buffer word on a separate output bus, together with an output-enable that controls the external tristate pads. The element address comes from the address pins when address-enable is high. Otherwise an internal pointer supplies it; any command write clears the pointer, and each pointer-addressed element advances it.

The bridge cannot be stalled, so there is no back-pressure. Every accepted strobe cycle completes in that cycle, and the bridge must not issue more than one element per clock. Malformed strobe cycles are dropped and recorded in a sticky error flag.

Top module: `ppt_target_decoder`

## Requirements
- R1: Buffer write.
  - Preconditions: `sel_data`=1, write pair valid (`wr_hi`=1, `wr_lo_n`=0), read pair idle (`rd_hi`=0, `rd_lo_n`=1).
  - Effect: the word on `bus_in` is stored at the element address.
  - Observable: a later read of that address returns the word.
- R2: Buffer read.
  - Preconditions: a valid data-phase read (`sel_data`=1, `rd_hi`=1, `rd_lo_n`=0, write pair idle) sampled at an edge.
  - Effect: after that edge, `bus_out` holds the addressed entry and `bus_oe`=1.
  - Deassertion: `bus_oe` falls after the first edge that samples no valid data-phase read.
  - Command phase: a read in the command phase never raises `bus_oe`.
- R3: Command write.
  - Preconditions: `sel_data`=0 and a valid write.
  - Effect: `cmd_q` loads `bus_in`, and `cmd_stb` is 1 for exactly the following cycle.
  - The buffer is not written.
- R4: Address source.
  - With `addr_en`=1, `addr_in` is the element address.
  - With `addr_en`=0, the internal pointer is the element address and `addr_in` has no effect.
- R5: Pointer behaviour.
  - The pointer becomes 0 after every command write.
  - It advances by 1 after each accepted data element transferred with `addr_en`=0.
  - It wraps from 511 to 0.
- R6: Strobe pair disagreement.
  - A pair disagrees when both of its copies are 1 or both are 0.
  - If either pair disagrees, the cycle performs no transfer: no buffer write, no command load, no `bus_oe`.
  - `proto_err` is set.
- R7: Read and write together.
  - A valid read and a valid write in the same cycle are rejected in either phase: no transfer takes place.
  - `proto_err` is set.
- R8: `proto_err` stays 1 until reset, whatever traffic follows.
- R9: Byte mode.
  - With `byte_mode`=1, only `bus_in[7:0]` is stored or loaded into `cmd_q`, and the upper bits are stored as 0.
  - A read taken with `byte_mode`=1 drives the upper bits of `bus_out` to 0.
  - Each buffer address holds one byte.
- R10: Reset state. After reset, `bus_oe`=0, `bus_out`=0, `cmd_q`=0, `cmd_stb`=0 and `proto_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the bridge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = 8-bit port: only the low byte is used |
| sel_data | input | 1 | 0 = command transfer, 1 = data transfer |
| rd_hi | input | 1 | Read strobe, active-high copy |
| rd_lo_n | input | 1 | Read strobe, active-low copy |
| wr_hi | input | 1 | Write strobe, active-high copy |
| wr_lo_n | input | 1 | Write strobe, active-low copy |
| addr_en | input | 1 | 1 = use addr_in, 0 = use the internal pointer |
| addr_in | input | 9 | Element address |
| bus_in | input | 16 | Data bus as seen from the pads |
| bus_out | output | 16 | Read data toward the pads |
| bus_oe | output | 1 | Output enable for the data pads |
| cmd_q | output | 16 | Last command word |
| cmd_stb | output | 1 | One-cycle pulse after a command load |
| proto_err | output | 1 | Sticky strobe protocol error |

## Verification
The buffer is swept over all 512 addresses twice:
- once with explicit addresses and a per-address arithmetic pattern, which exposes aliasing and stuck address bits;
- once through the pointer, running a full lap plus one element, which shows the wrap and that `addr_in` is ignored.

Pointer traffic interleaved with explicit-address traffic separates "advance on every element" from "advance only on pointer elements". Byte-mode writes, reads and command loads, each compared with full-width ones, show which bits are masked. Each illegal strobe combination is applied after a fresh reset, with a known buffer word at stake. This ties the error flag and the suppressed transfer to that one pattern.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

  // Operation decoded from one sampled strobe cycle
  typedef enum logic [2:0] {
    OP_NONE,
    OP_CMD_WR,
    OP_DAT_WR,
    OP_DAT_RD,
    OP_BAD
  } op_e;

endpackage

// File: rtl/ppt_strobe_decode.sv
module ppt_strobe_decode
  import ppt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_data,
  input  logic rd_hi,
  input  logic rd_lo_n,
  input  logic wr_hi,
  input  logic wr_lo_n,
  output op_e  op,
  output logic proto_err
);

  logic rd_bad, wr_bad, rd_on, wr_on, reject;

  // A pair is malformed when both copies carry the same level
  assign rd_bad = (rd_hi == rd_lo_n);
  assign wr_bad = (wr_hi == wr_lo_n);
  assign rd_on  = rd_hi & ~rd_lo_n;
  assign wr_on  = wr_hi & ~wr_lo_n;
  assign reject = rd_bad | wr_bad | (rd_on & wr_on);

  always_comb begin
    op = OP_NONE;
    if (reject)
      op = OP_BAD;
    else if (wr_on)
      op = sel_data ? OP_DAT_WR : OP_CMD_WR;
    else if (rd_on && sel_data)
      op = OP_DAT_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      proto_err <= 1'b0;
    else if (op == OP_BAD)
      proto_err <= 1'b1;
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err);

  // R6 R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past((rd_hi == rd_lo_n) || (wr_hi == wr_lo_n) || (rd_hi && wr_hi)));

endmodule

// File: rtl/ppt_addr_gen.sv
module ppt_addr_gen
  import ppt_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          addr_en,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] elem_addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  logic          elem, advance;

  assign elem      = (op == OP_DAT_WR) || (op == OP_DAT_RD);
  assign advance   = elem && !addr_en;
  assign elem_addr = addr_en ? addr_in : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (op == OP_CMD_WR)
      ptr <= '0;
    else if (advance)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_CMD_WR) |-> (ptr == '0));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_DAT_WR && !addr_en) |->
      (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

endmodule

// File: rtl/ppt_buffer.sv
module ppt_buffer #(
  parameter int DW    = 16,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_mask,
  output logic [DW-1:0] rdata,
  output logic          oe
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      oe    <= 1'b0;
    end else begin
      oe <= re;
      if (re)
        rdata <= mem[addr] & rd_mask;
    end
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/ppt_target_decoder.sv
module ppt_target_decoder
  import ppt_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_mode,
  input  logic             sel_data,
  input  logic             rd_hi,
  input  logic             rd_lo_n,
  input  logic             wr_hi,
  input  logic             wr_lo_n,
  input  logic             addr_en,
  input  logic [AW-1:0]    addr_in,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic [BUS_W-1:0] cmd_q,
  output logic             cmd_stb,
  output logic             proto_err
);

  op_e              op;
  logic [AW-1:0]    elem_addr;
  logic [BUS_W-1:0] low_mask, use_mask, wdata;

  generate
    if (BUS_W > 8) begin : g_wide
      assign low_mask = {{(BUS_W-8){1'b0}}, 8'hFF};
    end else begin : g_narrow
      assign low_mask = '1;
    end
  endgenerate

  assign use_mask = byte_mode ? low_mask : '1;
  assign wdata    = bus_in & use_mask;

  ppt_strobe_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_data  (sel_data),
    .rd_hi     (rd_hi),
    .rd_lo_n   (rd_lo_n),
    .wr_hi     (wr_hi),
    .wr_lo_n   (wr_lo_n),
    .op        (op),
    .proto_err (proto_err)
  );

  ppt_addr_gen #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .addr_en   (addr_en),
    .addr_in   (addr_in),
    .elem_addr (elem_addr)
  );

  ppt_buffer #(.DW(BUS_W), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (op == OP_DAT_WR),
    .re      (op == OP_DAT_RD),
    .addr    (elem_addr),
    .wdata   (wdata),
    .rd_mask (use_mask),
    .rdata   (bus_out),
    .oe      (bus_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      cmd_stb <= 1'b0;
    end else begin
      cmd_stb <= (op == OP_CMD_WR);
      if (op == OP_CMD_WR)
        cmd_q <= wdata;
    end
  end

  // R3
  cmd_stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(wr_hi && !wr_lo_n && !sel_data && !rd_hi && rd_lo_n));

  // R2
  oe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(rd_hi && !rd_lo_n && sel_data && !wr_hi && wr_lo_n));

  // R9
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(byte_mode)) |-> ((bus_out & ~low_mask) == '0));

endmodule

// File: tb/tb_ppt_target_decoder.sv
module tb_ppt_target_decoder;
  localparam int W = 16;
  localparam int D = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, byte_mode, sel_data, rd_hi, rd_lo_n, wr_hi, wr_lo_n, addr_en;
  logic [8:0]    addr_in;
  logic [W-1:0]  bus_in, bus_out, cmd_q;
  logic          bus_oe, cmd_stb, proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] model [D];

  ppt_target_decoder dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .sel_data(sel_data),
    .rd_hi(rd_hi), .rd_lo_n(rd_lo_n), .wr_hi(wr_hi), .wr_lo_n(wr_lo_n),
    .addr_en(addr_en), .addr_in(addr_in), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .cmd_q(cmd_q), .cmd_stb(cmd_stb), .proto_err(proto_err)
  );

  function automatic logic [15:0] pat(int a, int salt);
    return 16'((a * 40503 + salt * 977) ^ (a << 5));
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply one cycle of pins, return at the next falling edge
  task automatic put(bit sel, bit rh, bit rl, bit wh, bit wl, bit aen,
                     logic [8:0] a, logic [15:0] d);
    sel_data = sel; rd_hi = rh; rd_lo_n = rl; wr_hi = wh; wr_lo_n = wl;
    addr_en = aen; addr_in = a; bus_in = d;
    @(negedge clk);
  endtask

  task automatic idle();              put(1, 0, 1, 0, 1, 1, 9'h0, 16'h0); endtask
  task automatic wr_x(logic [8:0] a, logic [15:0] d); put(1, 0, 1, 1, 0, 1, a, d); endtask
  task automatic wr_p(logic [8:0] junk, logic [15:0] d); put(1, 0, 1, 1, 0, 0, junk, d); endtask
  task automatic rd_x(logic [8:0] a);  put(1, 1, 0, 0, 1, 1, a, 16'hFFFF); endtask
  task automatic rd_p(logic [8:0] junk); put(1, 1, 0, 0, 1, 0, junk, 16'hFFFF); endtask
  task automatic cmd(logic [15:0] d);  put(0, 0, 1, 1, 0, 1, 9'h0, d); endtask

  task automatic do_reset();
    rst_n = 1'b0; byte_mode = 1'b0;
    sel_data = 1; rd_hi = 0; rd_lo_n = 1; wr_hi = 0; wr_lo_n = 1;
    addr_en = 1; addr_in = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk(bus_oe == 0,    "R10 oe",  bus_oe, 0);
    chk(bus_out == 0,   "R10 out", bus_out, 0);
    chk(cmd_q == 0,     "R10 cmd", cmd_q, 0);
    chk(cmd_stb == 0,   "R10 stb", cmd_stb, 0);
    chk(proto_err == 0, "R10 err", proto_err, 0);

    // R1 R2 explicit-address sweep
    for (int a = 0; a < D; a++) begin
      wr_x(9'(a), pat(a, 1));
      model[a] = pat(a, 1);
    end
    for (int a = 0; a < D; a++) begin
      rd_x(9'(a));
      chk(bus_out == model[a], "R1 readback", bus_out, model[a]);
      chk(bus_oe == 1,         "R2 oe on",    bus_oe, 1);
    end
    idle();
    chk(bus_oe == 0, "R2 oe drop", bus_oe, 0);
    put(0, 1, 0, 0, 1, 1, 9'h3, 16'h0);
    chk(bus_oe == 0, "R2 cmd-phase read", bus_oe, 0);
    chk(proto_err == 0, "R6 no false error", proto_err, 0);

    // R3 command load
    cmd(16'h1234);
    chk(cmd_q == 16'h1234, "R3 cmd_q", cmd_q, 16'h1234);
    chk(cmd_stb == 1,      "R3 stb on", cmd_stb, 1);
    idle();
    chk(cmd_stb == 0,      "R3 stb off", cmd_stb, 0);
    rd_x(9'h0);
    chk(bus_out == model[0], "R3 buffer untouched", bus_out, model[0]);

    // R4 R5 pointer writes with junk addr_in
    cmd(16'h0001);
    for (int i = 0; i < 40; i++) begin
      wr_p(9'h1FF ^ 9'(i), pat(i, 7));
      model[i] = pat(i, 7);
    end
    cmd(16'h0002);
    for (int i = 0; i < 40; i++) begin
      rd_p(9'h0AA);
      chk(bus_out == model[i], "R5 pointer read", bus_out, model[i]);
    end
    rd_x(9'h1F0);
    chk(bus_out == model[9'h1F0], "R4 addr_in ignored", bus_out, model[9'h1F0]);

    // R5 explicit element does not move the pointer
    cmd(16'h0003);
    wr_p(9'h0, 16'hA001); model[0] = 16'hA001;
    wr_x(9'd100, 16'hB002); model[100] = 16'hB002;
    wr_p(9'h0, 16'hA003); model[1] = 16'hA003;
    cmd(16'h0004);
    rd_p(9'h0);
    chk(bus_out == 16'hA001, "R5 ptr slot0", bus_out, 16'hA001);
    rd_p(9'h0);
    chk(bus_out == 16'hA003, "R5 ptr slot1", bus_out, 16'hA003);

    // R5 wrap: full lap plus one
    cmd(16'h0005);
    for (int i = 0; i < D; i++) begin
      wr_p(9'(i * 3), pat(i, 3));
      model[i] = pat(i, 3);
    end
    wr_p(9'h55, 16'hC0DE); model[0] = 16'hC0DE;
    for (int a = 0; a < D; a++) begin
      rd_x(9'(a));
      chk(bus_out == model[a], "R5 wrap sweep", bus_out, model[a]);
    end
    idle();

    // R9 byte mode
    byte_mode = 1;
    wr_x(9'd5, 16'hABCD); model[5] = 16'h00CD;
    byte_mode = 0;
    rd_x(9'd5);
    chk(bus_out == 16'h00CD, "R9 byte store", bus_out, 16'h00CD);
    byte_mode = 1;
    rd_x(9'd6);
    chk(bus_out == (model[6] & 16'h00FF), "R9 byte read", bus_out, model[6] & 16'h00FF);
    cmd(16'hBEEF);
    chk(cmd_q == 16'h00EF, "R9 byte cmd", cmd_q, 16'h00EF);
    byte_mode = 0;
    idle();

    // R6 mismatched pairs, one per reset
    do_reset();
    put(1, 0, 1, 1, 1, 1, 9'd7, 16'hDEAD);
    chk(proto_err == 1, "R6 wr both high", proto_err, 1);
    rd_x(9'd7);
    chk(bus_out == model[7], "R6 wr both high no store", bus_out, model[7]);

    do_reset();
    put(1, 0, 0, 1, 0, 1, 9'd7, 16'hDEAD);
    chk(proto_err == 1, "R6 rd both low", proto_err, 1);
    rd_x(9'd7);
    chk(bus_out == model[7], "R6 rd both low no store", bus_out, model[7]);

    do_reset();
    put(1, 1, 1, 0, 1, 1, 9'd7, 16'h0);
    chk(proto_err == 1, "R6 rd both high", proto_err, 1);
    chk(bus_oe == 0,    "R6 rd both high no oe", bus_oe, 0);

    do_reset();
    put(0, 0, 1, 0, 0, 1, 9'd0, 16'h4444);
    chk(proto_err == 1, "R6 wr both low", proto_err, 1);
    chk(cmd_q == 0,     "R6 wr both low no cmd", cmd_q, 0);

    // R7 read and write together
    do_reset();
    put(1, 1, 0, 1, 0, 1, 9'd7, 16'hDEAD);
    chk(proto_err == 1, "R7 data err", proto_err, 1);
    chk(bus_oe == 0,    "R7 data no oe", bus_oe, 0);
    rd_x(9'd7);
    chk(bus_out == model[7], "R7 data no store", bus_out, model[7]);

    do_reset();
    put(0, 1, 0, 1, 0, 1, 9'd0, 16'h7777);
    chk(proto_err == 1, "R7 cmd err", proto_err, 1);
    chk(cmd_q == 0 && cmd_stb == 0, "R7 cmd no load", cmd_q, 0);

    // R8 sticky
    wr_x(9'd9, 16'h1111); model[9] = 16'h1111;
    repeat (5) idle();
    chk(proto_err == 1, "R8 sticky", proto_err, 1);
    do_reset();
    chk(proto_err == 0, "R8 cleared by reset", proto_err, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule